// File: doc/BRIEF.md
# LCD Panel Power Sequencer

This block powers a parallel-RGB TFT panel up and down in a fixed, safe order. When `pwr_req` goes high it first turns on the panel supply and waits a minimum settling time. It then opens the gate that passes data-enable and the pixel bus from the video source to the panel. Once the source reports valid pixel data, and after a programmable delay, it raises the display-on line. After a long settling period it starts driving the backlight enable as a PWM waveform, and `panel_ready` goes high.

When `pwr_req` drops, the steps are undone in reverse order, each after its own delay: backlight off, display off, data gated off, supply off. A drop during power-up leaves the up path at once and joins the down path at the step that matches the current stage.

All delays are given in microseconds and turned into clock cycles from the `CLK_HZ` parameter. A bench can therefore shrink them by declaring a slow clock. In the requirements below, a delay of `T` microseconds is `C(T) = CLK_HZ*T/1000000` cycles. "Edge" means a rising edge of `clk`.

Top module: `lcd_pwr_seq`

## Requirements
- R1: While `rst` is high at an edge, the sequencer returns to off. After that edge `supply_en`, `de_out`, `pix_out`, `disp_on`, `bl_en` and `panel_ready` are all 0, and the timers and the PWM counter are cleared.
- R2: From off, an edge that samples `pwr_req` high raises `supply_en` after that same edge. The data gate opens exactly C(T_SUP_US)+1 cycles after `supply_en` rises.
- R3: While the data gate is open, `de_out` equals `de_in` and `pix_out` equals `pix_in`. At all other times both are forced to 0.
- R4: The sequencer waits with the gate open for as long as `pix_valid` stays low. `disp_on` rises exactly C(T_DISP_US)+1 cycles after the first edge that samples `pix_valid` high.
- R5: At elaboration the parameters must satisfy these ranges, or elaboration stops: T_SUP_US in 500..100000, T_DISP_US in 0..200000, T_BL_US at least 160000.
- R6: `panel_ready` rises exactly C(T_BL_US)+1 cycles after `disp_on`. `bl_en` can be high only while `panel_ready` is high, and its first pulse comes one cycle after `panel_ready` rises when `duty` > 0.
- R7: While ready, `bl_en` repeats with a period of PWM_PERIOD cycles and is high for `duty` cycles of each period. A `duty` of 0 keeps it low, and a `duty` of PWM_PERIOD or more keeps it high.
- R8: If `pwr_req` is sampled low while ready, the following happens, measured from the sampling edge E with D = C(T_DN_US): `panel_ready` and `bl_en` fall after E, `disp_on` falls D+1 cycles after E, the gate closes after a further D+1 cycles, and `supply_en` falls after a further D+1 cycles.
- R9: If `pwr_req` is sampled low during power-up, the up path is abandoned. Before the gate opens, `supply_en` falls D+1 cycles later. After the gate opens but before `disp_on`, the gate closes D+1 cycles later and `supply_en` falls D+1 cycles after that. `disp_on` is never raised.
- R10: At every cycle, `bl_en` implies `disp_on`, `panel_ready` implies `disp_on`, and `disp_on` and `de_out` each imply `supply_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_req | input | 1 | High requests the panel on, low requests it off |
| pix_valid | input | 1 | Video source reports valid pixel data |
| de_in | input | 1 | Data-enable from the video source |
| pix_in | input | PIX_W | Pixel bus from the video source |
| duty | input | $clog2(PWM_PERIOD+1) | Backlight on-cycles per PWM period |
| supply_en | output | 1 | Panel supply enable |
| de_out | output | 1 | Gated data-enable to the panel |
| pix_out | output | PIX_W | Gated pixel bus to the panel |
| disp_on | output | 1 | Display-on line to the panel |
| bl_en | output | 1 | PWM backlight enable |
| panel_ready | output | 1 | Panel fully on with the backlight running |

## Verification
The assertions check on every cycle the enable-order invariants of R10, the one-step countdown of each timer, the PWM counter bound, the requirement that supply only rises on a request, and the rule that neither display-on nor ready can rise while the request is low. The exact delay of each stage, the duty-cycle counts, the reverse-order power-down timings and the two abort paths can only be shown by the bench's directed scenarios. These scenarios count cycles between output edges and compare them with values derived from the parameters.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_SUPPLY,
        ST_PIXWAIT,
        ST_DISPDLY,
        ST_BLDLY,
        ST_RUN,
        ST_DN_BL,
        ST_DN_DISP,
        ST_DN_DATA
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
    } seq_regs_t;

    function automatic longint unsigned us_to_cycles(longint unsigned clk_hz,
                                                     longint unsigned us);
        return (clk_hz * us) / 64'd1000000;
    endfunction

endpackage

// File: rtl/lcd_seq_timer.sv
module lcd_seq_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          done
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - TW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);

    // each idle cycle takes exactly one count off a running delay
    p_timer_step_r2: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - TW'(1)));

    p_timer_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/lcd_bl_pwm.sv
module lcd_bl_pwm #(
    parameter int PERIOD = 256,
    parameter int DW     = $clog2(PERIOD + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [DW-1:0] duty,
    output logic          pwm
);
    localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;

    logic [CW-1:0] cnt_d, cnt_q;
    logic          pwm_d, pwm_q;

    always_comb begin
        if (!en)
            cnt_d = '0;
        else if (cnt_q == CW'(PERIOD - 1))
            cnt_d = '0;
        else
            cnt_d = cnt_q + CW'(1);
        pwm_d = en && (DW'(cnt_q) < duty);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            pwm_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            pwm_q <= pwm_d;
        end
    end

    assign pwm = pwm_q;

    p_pwm_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        32'(cnt_q) < PERIOD);

    p_pwm_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !en |=> !pwm);

endmodule

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq
    import lcd_seq_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 100_000_000,
    parameter int unsigned T_SUP_US   = 1000,
    parameter int unsigned T_DISP_US  = 10000,
    parameter int unsigned T_BL_US    = 160000,
    parameter int unsigned T_DN_US    = 1000,
    parameter int          PIX_W      = 24,
    parameter int          PWM_PERIOD = 256,
    parameter int          DW         = $clog2(PWM_PERIOD + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_req,
    input  logic             pix_valid,
    input  logic             de_in,
    input  logic [PIX_W-1:0] pix_in,
    input  logic [DW-1:0]    duty,
    output logic             supply_en,
    output logic             de_out,
    output logic [PIX_W-1:0] pix_out,
    output logic             disp_on,
    output logic             bl_en,
    output logic             panel_ready
);
    localparam longint unsigned C_SUP  = us_to_cycles(64'(CLK_HZ), 64'(T_SUP_US));
    localparam longint unsigned C_DISP = us_to_cycles(64'(CLK_HZ), 64'(T_DISP_US));
    localparam longint unsigned C_BL   = us_to_cycles(64'(CLK_HZ), 64'(T_BL_US));
    localparam longint unsigned C_DN   = us_to_cycles(64'(CLK_HZ), 64'(T_DN_US));
    localparam longint unsigned C_M1   = (C_SUP > C_DISP) ? C_SUP : C_DISP;
    localparam longint unsigned C_M2   = (C_BL > C_DN) ? C_BL : C_DN;
    localparam longint unsigned C_MAX  = (C_M1 > C_M2) ? C_M1 : C_M2;
    localparam int              TW     = (C_MAX > 1) ? $clog2(C_MAX + 1) : 1;

    // R5: parameter ranges checked at elaboration
    if (T_SUP_US < 500 || T_SUP_US > 100000) begin : g_bad_sup
        $error("supply settle delay out of range 500..100000 us");
    end
    if (T_DISP_US > 200000) begin : g_bad_disp
        $error("display-on delay above 200000 us");
    end
    if (T_BL_US < 160000) begin : g_bad_bl
        $error("backlight settle delay below 160000 us");
    end
    if (PWM_PERIOD < 2) begin : g_bad_pwm
        $error("PWM period must be at least 2");
    end

    seq_regs_t     r_d, r_q;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_done;
    logic          gate_open;
    logic          running;
    logic          pwm_raw;

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (r_q.state)
            ST_OFF: if (pwr_req) begin
                r_d.state = ST_SUPPLY;
                tmr_load  = 1'b1;
                tmr_val   = TW'(C_SUP);
            end
            ST_SUPPLY: if (!pwr_req) begin
                r_d.state = ST_DN_DATA;
                tmr_load  = 1'b1;
                tmr_val   = TW'(C_DN);
            end else if (tmr_done) begin
                r_d.state = ST_PIXWAIT;
            end
            ST_PIXWAIT: if (!pwr_req) begin
                r_d.state = ST_DN_DISP;
                tmr_load  = 1'b1;
                tmr_val   = TW'(C_DN);
            end else if (pix_valid) begin
                r_d.state = ST_DISPDLY;
                tmr_load  = 1'b1;
                tmr_val   = TW'(C_DISP);
            end
            ST_DISPDLY: if (!pwr_req) begin
                r_d.state = ST_DN_DISP;
                tmr_load  = 1'b1;
                tmr_val   = TW'(C_DN);
            end else if (tmr_done) begin
                r_d.state = ST_BLDLY;
                tmr_load  = 1'b1;
                tmr_val   = TW'(C_BL);
            end
            ST_BLDLY: if (!pwr_req) begin
                r_d.state = ST_DN_BL;
                tmr_load  = 1'b1;
                tmr_val   = TW'(C_DN);
            end else if (tmr_done) begin
                r_d.state = ST_RUN;
            end
            ST_RUN: if (!pwr_req) begin
                r_d.state = ST_DN_BL;
                tmr_load  = 1'b1;
                tmr_val   = TW'(C_DN);
            end
            ST_DN_BL: if (tmr_done) begin
                r_d.state = ST_DN_DISP;
                tmr_load  = 1'b1;
                tmr_val   = TW'(C_DN);
            end
            ST_DN_DISP: if (tmr_done) begin
                r_d.state = ST_DN_DATA;
                tmr_load  = 1'b1;
                tmr_val   = TW'(C_DN);
            end
            ST_DN_DATA: if (tmr_done) begin
                r_d.state = ST_OFF;
            end
            default: r_d.state = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '{state: ST_OFF};
        else     r_q <= r_d;
    end

    lcd_seq_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    lcd_bl_pwm #(.PERIOD(PWM_PERIOD), .DW(DW)) u_pwm (
        .clk  (clk),
        .rst  (rst),
        .en   (running),
        .duty (duty),
        .pwm  (pwm_raw)
    );

    always_comb begin
        running   = (r_q.state == ST_RUN);
        gate_open = r_q.state inside {ST_PIXWAIT, ST_DISPDLY, ST_BLDLY,
                                      ST_RUN, ST_DN_BL, ST_DN_DISP};
        supply_en   = (r_q.state != ST_OFF);
        disp_on     = r_q.state inside {ST_BLDLY, ST_RUN, ST_DN_BL};
        panel_ready = running;
        bl_en       = running && pwm_raw;
        de_out      = gate_open && de_in;
        pix_out     = gate_open ? pix_in : '0;
    end

    p_bl_needs_disp_r10: assert property (@(posedge clk) disable iff (rst)
        bl_en |-> disp_on);
    p_disp_needs_supply_r10: assert property (@(posedge clk) disable iff (rst)
        disp_on |-> supply_en);
    p_de_needs_supply_r10: assert property (@(posedge clk) disable iff (rst)
        de_out |-> supply_en);
    p_ready_needs_disp_r6: assert property (@(posedge clk) disable iff (rst)
        panel_ready |-> disp_on);
    p_supply_on_request_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(supply_en) |-> $past(pwr_req));
    p_disp_after_gate_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(disp_on) |-> $past(gate_open));
    p_no_rise_when_off_r9: assert property (@(posedge clk) disable iff (rst)
        !pwr_req |=> (!$rose(disp_on) && !$rose(panel_ready)));
    p_ready_drops_r8: assert property (@(posedge clk) disable iff (rst)
        (!pwr_req && panel_ready) |=> !panel_ready);

endmodule

// File: tb/lcd_pwr_seq_tb.sv
module lcd_pwr_seq_tb;
    localparam int unsigned CLK_HZ    = 100_000;
    localparam int unsigned T_SUP_US  = 500;
    localparam int unsigned T_DISP_US = 1000;
    localparam int unsigned T_BL_US   = 160000;
    localparam int unsigned T_DN_US   = 200;
    localparam int PIX_W  = 8;
    localparam int PER    = 16;
    localparam int DW     = $clog2(PER + 1);
    localparam int C_SUP  = int'((longint'(CLK_HZ) * T_SUP_US) / 1000000);
    localparam int C_DISP = int'((longint'(CLK_HZ) * T_DISP_US) / 1000000);
    localparam int C_BL   = int'((longint'(CLK_HZ) * T_BL_US) / 1000000);
    localparam int C_DN   = int'((longint'(CLK_HZ) * T_DN_US) / 1000000);

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst = 1'b1, pwr_req = 1'b0, pix_valid = 1'b1, de_in = 1'b1;
    logic [PIX_W-1:0] pix_in = 8'h3C;
    logic [DW-1:0] duty = DW'(5);
    logic supply_en, de_out, disp_on, bl_en, panel_ready;
    logic [PIX_W-1:0] pix_out;

    int checks = 0, errors = 0, order_bad = 0;
    bit finished = 1'b0;

    lcd_pwr_seq #(
        .CLK_HZ(CLK_HZ), .T_SUP_US(T_SUP_US), .T_DISP_US(T_DISP_US),
        .T_BL_US(T_BL_US), .T_DN_US(T_DN_US), .PIX_W(PIX_W), .PWM_PERIOD(PER)
    ) u_dut (
        .clk(clk), .rst(rst), .pwr_req(pwr_req), .pix_valid(pix_valid),
        .de_in(de_in), .pix_in(pix_in), .duty(duty), .supply_en(supply_en),
        .de_out(de_out), .pix_out(pix_out), .disp_on(disp_on), .bl_en(bl_en),
        .panel_ready(panel_ready)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic pick(input int s);
        case (s)
            0: return supply_en;
            1: return de_out;
            2: return disp_on;
            3: return panel_ready;
            default: return bl_en;
        endcase
    endfunction

    task automatic wait_sig(input int s, input logic v, output int n);
        n = 0;
        while (pick(s) !== v && n < 40000) begin
            @(negedge clk);
            n++;
        end
    endtask

    // R10 order monitor
    always @(negedge clk)
        if (!rst && ((bl_en && !disp_on) || (panel_ready && !disp_on) ||
                     (disp_on && !supply_en) || (de_out && !supply_en)))
            order_bad++;

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk({supply_en, de_out, disp_on, bl_en, panel_ready} == 5'b0 && pix_out == '0,
            "R1", "outputs in reset", {supply_en, de_out, disp_on, bl_en, panel_ready}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(supply_en == 1'b0, "R1", "supply after reset", supply_en, 0);
    endtask

    task automatic t_power_up();
        int n;
        pwr_req = 1'b1;
        wait_sig(0, 1'b1, n);
        chk(n == 1, "R2", "supply rise", n, 1);
        chk(pix_out == '0, "R3", "pix before gate", pix_out, 0);
        wait_sig(1, 1'b1, n);
        chk(n == C_SUP + 1, "R2", "supply to gate", n, C_SUP + 1);
        chk(n >= (CLK_HZ / 2000), "R5", "supply settle at least 0.5 ms", n, CLK_HZ / 2000);
        chk(pix_out == pix_in, "R3", "pix pass", pix_out, pix_in);
        wait_sig(2, 1'b1, n);
        chk(n == C_DISP + 2, "R4", "gate to display-on", n, C_DISP + 2);
        wait_sig(3, 1'b1, n);
        chk(n == C_BL + 1, "R6", "display-on to ready", n, C_BL + 1);
        chk(bl_en == 1'b0, "R6", "bl at ready", bl_en, 0);
        @(negedge clk);
        chk(bl_en == 1'b1, "R6", "first bl pulse", bl_en, 1);
    endtask

    task automatic t_pwm(input int d);
        int hi = 0;
        int exp = (d > PER ? PER : d) * 4;
        duty = DW'(d);
        repeat (PER) @(negedge clk);
        for (int i = 0; i < 4 * PER; i++) begin
            if (bl_en) hi++;
            @(negedge clk);
        end
        chk(hi == exp, "R7", $sformatf("high cycles duty %0d", d), hi, exp);
    endtask

    task automatic t_gate();
        de_in = 1'b0; pix_in = 8'hA5;
        @(negedge clk);
        chk(de_out == 1'b0 && pix_out == 8'hA5, "R3", "de follow low / pix follow",
            {de_out, pix_out}, 9'h0A5);
        de_in = 1'b1;
        @(negedge clk);
        chk(de_out == 1'b1, "R3", "de follow high", de_out, 1);
    endtask

    task automatic t_power_down();
        int n;
        pwr_req = 1'b0;
        wait_sig(3, 1'b0, n);
        chk(n == 1 && bl_en == 1'b0, "R8", "ready/bl fall", n, 1);
        wait_sig(2, 1'b0, n);
        chk(n == C_DN + 1, "R8", "display-off delay", n, C_DN + 1);
        wait_sig(1, 1'b0, n);
        chk(n == C_DN + 1, "R8", "gate-off delay", n, C_DN + 1);
        wait_sig(0, 1'b0, n);
        chk(n == C_DN + 1, "R8", "supply-off delay", n, C_DN + 1);
        chk(pix_out == '0, "R3", "pix forced low when off", pix_out, 0);
    endtask

    task automatic t_pix_hold_abort();
        int n;
        pix_valid = 1'b0;
        pwr_req = 1'b1;
        wait_sig(1, 1'b1, n);
        repeat (300) @(negedge clk);
        chk(disp_on == 1'b0, "R4", "waits for pix_valid", disp_on, 0);
        pix_valid = 1'b1;
        wait_sig(2, 1'b1, n);
        chk(n == C_DISP + 2, "R4", "pix_valid to display-on", n, C_DISP + 2);
        chk(n <= int'((longint'(CLK_HZ) * 200000) / 1000000) + 2, "R5",
            "display delay within 200 ms", n, C_DISP + 2);
        pwr_req = 1'b0;
        repeat (C_DN + 1) @(negedge clk);
        chk(disp_on == 1'b1, "R8", "abort from display stage holds disp", disp_on, 1);
        @(negedge clk);
        chk(disp_on == 1'b0, "R8", "abort from display stage drops disp", disp_on, 0);
        wait_sig(0, 1'b0, n);
        chk(n == 2 * C_DN + 2, "R8", "abort from display stage supply-off", n, 2 * C_DN + 2);
    endtask

    task automatic t_abort_dispdly();
        int n;
        pwr_req = 1'b1;
        wait_sig(1, 1'b1, n);
        repeat (10) @(negedge clk);
        pwr_req = 1'b0;
        repeat (C_DN + 1) @(negedge clk);
        chk(de_out == 1'b1 && disp_on == 1'b0, "R9", "gate held, no display",
            {de_out, disp_on}, 2'b10);
        @(negedge clk);
        chk(de_out == 1'b0, "R9", "gate closed", de_out, 0);
        repeat (C_DN) @(negedge clk);
        chk(supply_en == 1'b1, "R9", "supply held", supply_en, 1);
        @(negedge clk);
        chk(supply_en == 1'b0 && disp_on == 1'b0, "R9", "supply off, never displayed",
            {supply_en, disp_on}, 0);
    endtask

    task automatic t_abort_supply();
        pwr_req = 1'b1;
        repeat (10) @(negedge clk);
        chk(supply_en == 1'b1 && de_out == 1'b0, "R9", "in supply stage",
            {supply_en, de_out}, 2'b10);
        pwr_req = 1'b0;
        repeat (C_DN + 1) @(negedge clk);
        chk(supply_en == 1'b1 && de_out == 1'b0, "R9", "supply held after abort",
            {supply_en, de_out}, 2'b10);
        @(negedge clk);
        chk(supply_en == 1'b0, "R9", "supply off after abort", supply_en, 0);
    endtask

    initial begin
        repeat (190000) @(negedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_power_up();
        t_pwm(5);
        t_pwm(0);
        t_pwm(PER);
        t_pwm(20);
        t_pwm(1);
        t_gate();
        t_power_down();
        repeat (5) @(negedge clk);
        t_abort_supply();
        repeat (5) @(negedge clk);
        t_abort_dispdly();
        repeat (5) @(negedge clk);
        t_pix_hold_abort();
        chk(order_bad == 0, "R10", "enable order violations", order_bad, 0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule